// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the register front end of a 16550-style serial port. It sits on a single-cycle 16-bit register bus and holds the divisor, interrupt enable, line control, modem control, scratch and global control words. It also keeps the receive holding byte and a sticky line status word. The serial shifter, the baud generator and any FIFOs live outside it. A transmit write becomes a one-cycle byte strobe towards the shifter. A byte handed in by the receiver waits in the holding register until software reads it.

Registers sit at a 4-byte stride from offset 0x00. Bit 7 of the line control word is the divisor access latch. While it is set, the two lowest slots reach the divisor low and high words. While it is clear, those slots reach the data byte and the interrupt enable word. Reading line status returns its sticky bits merged with the live flags, then clears the sticky part. Internal loopback turns each transmit write into one pending receive byte and cuts off the external receive input.

Top module: `uart_csr_bank`

## Requirements
- R1: After reset the divisor low word reads 0x0001, the interrupt identification word reads 0x0001 and line status reads 0x0060. Interrupt enable, divisor high, line control, modem control, scratch and global control all read 0x0000.
- R2: With line control bit 7 set, offset 0x00 reads and writes the divisor low word and offset 0x04 reads and writes the divisor high word, and a write at 0x00 produces no transmit strobe. With bit 7 clear, those offsets reach the data byte and the interrupt enable word.
- R3: Line control (0x0C), modem control (0x10), scratch (0x1C), global control (0x24) and interrupt enable store all 16 bits written. Interrupt identification (0x08) always reads 0x0001, and writes to it or to line status (0x14) change nothing.
- R4: Any access with `bus_size` other than 2'b01 (16-bit) sets `bus_err` and `bus_err_size` and changes no state, even when the offset is also unmapped.
- R5: A 16-bit access to an offset that is not a multiple of 4, to slot 6 (0x18), to slot 8 (0x20) or beyond 0x24 sets `bus_err` with `bus_err_size` low, reads 0 and changes no state.
- R6: A data write with the latch clear raises `tx_strobe` for the following cycle, with `tx_byte` equal to bits 7:0 of the written word.
- R7: An `rx_valid` byte (loopback off) is stored and sets data-ready, line status bit 0. A data read returns it and clears data-ready. A data read with no new byte returns the previous byte again.
- R8: A byte that arrives while data-ready is set sets overrun, line status bit 1, as a sticky bit. A byte that arrives in the same cycle as a data read does not count as an overrun.
- R9: A line status read returns the sticky bits ORed with live data-ready (bit 0) and with `tx_line_idle` on bit 5 and bit 6. The sticky bits then clear.
- R10: With modem control bit 4 set, a data write also loads its low byte as one pending receive byte, and `rx_valid` is ignored.
- R11: `irq_tx` pulses together with `tx_strobe` when interrupt enable bit 1 is set. `irq_rx` is high while interrupt enable bit 0 and data-ready are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| bus_addr | input | 6 | Byte offset in the bank |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_err | output | 1 | Access rejected |
| bus_err_size | output | 1 | Rejection caused by access size |
| tx_line_idle | input | 1 | Transmitter empty, live flag |
| rx_valid | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | Transmit byte valid, one cycle |
| tx_byte | output | 8 | Byte to transmit |
| irq_tx | output | 1 | Transmit interrupt event |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
A data-register read and a byte arrival from the receiver can fall in the same clock. The read then consumes the old byte while the new one takes its place. The bench first leaves one byte pending. It then issues the read in the very cycle `rx_valid` delivers a second byte. It checks that the read returns the first byte, that the next line status read shows data-ready without overrun, and that the next data read returns the second byte.

// File: rtl/ucsr_pkg.sv
// Package: shared slot numbers and bit positions for the UART register bank.
// Assumes a 16-bit register bus; slot numbers are bus offsets divided by the stride.
package ucsr_pkg;
    localparam int SLOT_COUNT   = 10;
    localparam int SLOT_DATA    = 0;
    localparam int SLOT_IEN     = 1;
    localparam int SLOT_IID     = 2;
    localparam int SLOT_LCTL    = 3;
    localparam int SLOT_MCTL    = 4;
    localparam int SLOT_LSTAT   = 5;
    localparam int SLOT_MSTAT   = 6;
    localparam int SLOT_SCRATCH = 7;
    localparam int SLOT_HOLE    = 8;
    localparam int SLOT_GCTL    = 9;

    localparam int LATCH_BIT    = 7;  // line control: divisor access latch
    localparam int LOOP_BIT     = 4;  // modem control: internal loopback
    localparam int RXIE_BIT     = 0;  // interrupt enable: receive
    localparam int TXIE_BIT     = 1;  // interrupt enable: transmit
    localparam int DR_BIT       = 0;  // line status: data ready
    localparam int OVR_BIT      = 1;  // line status: overrun
    localparam int THRE_BIT     = 5;  // line status: holding register empty
    localparam int TEMT_BIT     = 6;  // line status: transmitter empty

    localparam logic [1:0] SIZE_HALF = 2'b01;
endpackage

// File: rtl/ucsr_decode.sv
// Module: address and size decoder for the UART register bank.
// Purely combinational. A size error outranks an unmapped offset; both block the access.
module ucsr_decode
    import ucsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int STRIDE = 4
) (
    input  logic                         sel,
    input  logic [1:0]                   size,
    input  logic [ADDR_W-1:0]            addr,
    output logic [ADDR_W-$clog2(STRIDE)-1:0] slot,
    output logic                         hit,
    output logic                         err,
    output logic                         err_size
);
    localparam int OFS_W  = $clog2(STRIDE);
    localparam int SLOT_W = ADDR_W - OFS_W;

    logic misaligned;
    logic mapped;

    // Split the offset into slot index and in-word byte bits, then classify.
    always_comb begin
        slot       = addr[ADDR_W-1:OFS_W];
        misaligned = |addr[OFS_W-1:0];
        mapped     = !misaligned
                     && (slot < SLOT_W'(SLOT_COUNT))
                     && (slot != SLOT_W'(SLOT_MSTAT))
                     && (slot != SLOT_W'(SLOT_HOLE));
        err_size   = sel && (size != SIZE_HALF);
        err        = sel && (err_size || !mapped);
        hit        = sel && !err;
    end

    // R4: a size error is always reported as such
    always_comb begin
        if (sel && size != SIZE_HALF)
            p_size_first_r4: assert (err && err_size && !hit);
    end
endmodule

// File: rtl/ucsr_rxhold.sv
// Module: receive holding byte with a one-deep pending flag.
// Loopback selects the transmit write as the only source. A new byte wins over a
// same-cycle consume; an arrival while pending and not consumed is an overrun event.
module ucsr_rxhold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              ext_valid,
    input  logic [BYTE_W-1:0] ext_byte,
    input  logic              lb_load,
    input  logic [BYTE_W-1:0] lb_byte,
    input  logic              consume,
    output logic [BYTE_W-1:0] rbr_q,
    output logic              pend_q,
    output logic              ovr_evt
);
    logic              arrive;
    logic [BYTE_W-1:0] arr_byte;

    // Pick the receive source according to loopback.
    always_comb begin
        arrive   = loop_en ? lb_load : ext_valid;
        arr_byte = loop_en ? lb_byte : ext_byte;
        ovr_evt  = arrive && pend_q && !consume;
    end

    // Hold the latest byte and track whether it is unread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q  <= '0;
            pend_q <= 1'b0;
        end else if (arrive) begin
            rbr_q  <= arr_byte;
            pend_q <= 1'b1;
        end else if (consume) begin
            pend_q <= 1'b0;
        end
    end

    // R10: external bytes do not reach the holding register in loopback
    p_loop_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && ext_valid && !lb_load) |=> $stable(rbr_q));

    // R7: a read with no arrival leaves nothing pending
    p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !(loop_en ? lb_load : ext_valid)) |=> !pend_q);
endmodule

// File: rtl/ucsr_lstat.sv
// Module: sticky line status word plus live flags.
// The sticky word resets to holding-empty and transmitter-empty. A read clears it,
// except that an overrun arriving in the same cycle survives the clear.
module ucsr_lstat
    import ucsr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovr_evt,
    input  logic              rd_clear,
    input  logic              dr_live,
    input  logic              tx_idle,
    output logic [BYTE_W-1:0] lsr_view
);
    localparam logic [BYTE_W-1:0] RST_WORD = BYTE_W'((1 << THRE_BIT) | (1 << TEMT_BIT));
    localparam logic [BYTE_W-1:0] OVR_MASK = BYTE_W'(1 << OVR_BIT);

    logic [BYTE_W-1:0] sticky_q;
    logic [BYTE_W-1:0] live;

    // Assemble the live flags.
    always_comb begin
        live           = '0;
        live[DR_BIT]   = dr_live;
        live[THRE_BIT] = tx_idle;
        live[TEMT_BIT] = tx_idle;
        lsr_view       = sticky_q | live;
    end

    // Accumulate sticky bits and clear them on read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= RST_WORD;
        else if (rd_clear)
            sticky_q <= ovr_evt ? OVR_MASK : '0;
        else if (ovr_evt)
            sticky_q <= sticky_q | OVR_MASK;
    end

    // R8: an overrun is always remembered
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> sticky_q[OVR_BIT]);

    // R9: a read with no new event leaves the sticky word empty
    p_lsr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !ovr_evt) |=> (sticky_q == '0));
endmodule

// File: rtl/uart_csr_bank.sv
// Module: UART control and status register bank (top).
// Single-cycle bus: read data and error are combinational in the access cycle,
// state changes at the following edge. The divisor latch aliases slots 0 and 1.
module uart_csr_bank
    import ucsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int STRIDE = 4,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              bus_err_size,
    input  logic              tx_line_idle,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq_tx,
    output logic              irq_rx
);
    localparam int SLOT_W = ADDR_W - $clog2(STRIDE);
    localparam int PAD_W  = DATA_W - BYTE_W;
    localparam logic [DATA_W-1:0] IID_WORD = DATA_W'(1);
    localparam logic [DATA_W-1:0] DIVL_RST = DATA_W'(1);

    logic [SLOT_W-1:0] slot;
    logic              hit;
    logic [DATA_W-1:0] dll_q, dlh_q, ier_q, lcr_q, mcr_q, scr_q, gctl_q;
    logic              latch, wr_hit, rd_hit, thr_wr, rbr_rd, lsr_rd;
    logic [BYTE_W-1:0] rbr_q, lsr_view;
    logic              pend_q, ovr_evt;

    ucsr_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
        .sel(bus_sel), .size(bus_size), .addr(bus_addr),
        .slot(slot), .hit(hit), .err(bus_err), .err_size(bus_err_size)
    );

    // Qualify accesses and the aliased data-slot operations.
    always_comb begin
        latch  = lcr_q[LATCH_BIT];
        wr_hit = hit && bus_wr;
        rd_hit = hit && !bus_wr;
        thr_wr = wr_hit && slot == SLOT_W'(SLOT_DATA) && !latch;
        rbr_rd = rd_hit && slot == SLOT_W'(SLOT_DATA) && !latch;
        lsr_rd = rd_hit && slot == SLOT_W'(SLOT_LSTAT);
    end

    ucsr_rxhold #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .loop_en(mcr_q[LOOP_BIT]),
        .ext_valid(rx_valid), .ext_byte(rx_byte),
        .lb_load(thr_wr), .lb_byte(bus_wdata[BYTE_W-1:0]),
        .consume(rbr_rd), .rbr_q(rbr_q), .pend_q(pend_q), .ovr_evt(ovr_evt)
    );

    ucsr_lstat #(.BYTE_W(BYTE_W)) u_ls (
        .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .rd_clear(lsr_rd),
        .dr_live(pend_q), .tx_idle(tx_line_idle), .lsr_view(lsr_view)
    );

    // Store writable registers; identification and line status ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_q  <= DIVL_RST;
            dlh_q  <= '0;
            ier_q  <= '0;
            lcr_q  <= '0;
            mcr_q  <= '0;
            scr_q  <= '0;
            gctl_q <= '0;
        end else if (wr_hit) begin
            case (slot)
                SLOT_W'(SLOT_DATA):    if (latch) dll_q <= bus_wdata;
                SLOT_W'(SLOT_IEN):     if (latch) dlh_q <= bus_wdata;
                                       else       ier_q <= bus_wdata;
                SLOT_W'(SLOT_LCTL):    lcr_q  <= bus_wdata;
                SLOT_W'(SLOT_MCTL):    mcr_q  <= bus_wdata;
                SLOT_W'(SLOT_SCRATCH): scr_q  <= bus_wdata;
                SLOT_W'(SLOT_GCTL):    gctl_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Launch the transmit byte and the transmit interrupt event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
            irq_tx    <= 1'b0;
        end else begin
            tx_strobe <= thr_wr;
            irq_tx    <= thr_wr && ier_q[TXIE_BIT];
            if (thr_wr)
                tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    // Receive interrupt request level.
    always_comb irq_rx = ier_q[RXIE_BIT] && pend_q;

    // Read multiplexer; rejected accesses read zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (slot)
                SLOT_W'(SLOT_DATA):    bus_rdata = latch ? dll_q : {{PAD_W{1'b0}}, rbr_q};
                SLOT_W'(SLOT_IEN):     bus_rdata = latch ? dlh_q : ier_q;
                SLOT_W'(SLOT_IID):     bus_rdata = IID_WORD;
                SLOT_W'(SLOT_LCTL):    bus_rdata = lcr_q;
                SLOT_W'(SLOT_MCTL):    bus_rdata = mcr_q;
                SLOT_W'(SLOT_LSTAT):   bus_rdata = {{PAD_W{1'b0}}, lsr_view};
                SLOT_W'(SLOT_SCRATCH): bus_rdata = scr_q;
                SLOT_W'(SLOT_GCTL):    bus_rdata = gctl_q;
                default:               bus_rdata = '0;
            endcase
        end
    end

    // R4 and R5: a rejected access leaves the stored registers untouched
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> ($stable(lcr_q) && $stable(scr_q) && $stable(ier_q)
                     && $stable(dll_q) && $stable(mcr_q) && $stable(gctl_q)));

    // R11: a transmit interrupt event only accompanies a transmit strobe
    p_txirq_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> tx_strobe);

    // R2: a write to the divisor low word never transmits
    p_latch_no_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && slot == SLOT_W'(SLOT_DATA) && lcr_q[LATCH_BIT]) |=> !tx_strobe);
endmodule

// File: tb/sim_uart_csr_bank.sv
`timescale 1ns/1ps
module sim_uart_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'b01;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err, bus_err_size;
    logic        tx_line_idle = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_strobe, irq_tx, irq_rx;
    logic [7:0]  tx_byte;

    int checks = 0, errors = 0;
    logic [15:0] r_data;
    logic        r_err, r_esz, p_stb, p_itx, p_irx;
    logic [7:0]  p_txb;

    always #4 clk = ~clk;

    uart_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_err_size(bus_err_size),
        .tx_line_idle(tx_line_idle), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // write flag, offset, write data, expected read data
    localparam int NV = 20;
    localparam logic [38:0] VEC [0:NV-1] = '{
        {1'b1, 6'h1C, 16'hBEEF, 16'h0000}, {1'b0, 6'h1C, 16'h0000, 16'hBEEF},
        {1'b1, 6'h24, 16'h1234, 16'h0000}, {1'b0, 6'h24, 16'h0000, 16'h1234},
        {1'b1, 6'h10, 16'h00A3, 16'h0000}, {1'b0, 6'h10, 16'h0000, 16'h00A3},
        {1'b1, 6'h04, 16'h00F0, 16'h0000}, {1'b0, 6'h04, 16'h0000, 16'h00F0},
        {1'b1, 6'h08, 16'hFFFF, 16'h0000}, {1'b0, 6'h08, 16'h0000, 16'h0001},
        {1'b1, 6'h0C, 16'h0083, 16'h0000}, {1'b0, 6'h0C, 16'h0000, 16'h0083},
        {1'b1, 6'h00, 16'h0056, 16'h0000}, {1'b0, 6'h00, 16'h0000, 16'h0056},
        {1'b1, 6'h04, 16'h0012, 16'h0000}, {1'b0, 6'h04, 16'h0000, 16'h0012},
        {1'b1, 6'h0C, 16'h0003, 16'h0000}, {1'b0, 6'h04, 16'h0000, 16'h00F0},
        {1'b1, 6'h14, 16'h00FF, 16'h0000}, {1'b0, 6'h00, 16'h0000, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [5:0] a, input logic [15:0] d,
                       input logic [1:0] sz, input logic rv, input logic [7:0] rb);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d; bus_size = sz;
        rx_valid = rv; rx_byte = rb;
        #1;
        r_data = bus_rdata; r_err = bus_err; r_esz = bus_err_size;
        @(posedge clk);
        #1;
        p_stb = tx_strobe; p_txb = tx_byte; p_itx = irq_tx; p_irx = irq_rx;
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0; bus_size = 2'b01;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        acc(1'b1, a, d, 2'b01, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [5:0] a);
        acc(1'b0, a, 16'h0000, 2'b01, 1'b0, 8'h00);
    endtask

    task automatic inject(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk);
        #1;
        p_irx = irq_rx;
        rx_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values (tx_line_idle low so line status shows only sticky bits)
        rd(6'h04); chk("R1 ien", r_data, 16'h0000);
        rd(6'h08); chk("R1 iid", r_data, 16'h0001);
        rd(6'h0C); chk("R1 lctl", r_data, 16'h0000);
        rd(6'h10); chk("R1 mctl", r_data, 16'h0000);
        rd(6'h1C); chk("R1 scratch", r_data, 16'h0000);
        rd(6'h24); chk("R1 gctl", r_data, 16'h0000);
        rd(6'h14); chk("R1 lstat", r_data, 16'h0060);
        rd(6'h14); chk("R9 lstat cleared", r_data, 16'h0000);
        wr(6'h0C, 16'h0080);
        rd(6'h00); chk("R1 divl", r_data, 16'h0001);
        rd(6'h04); chk("R1 divh", r_data, 16'h0000);
        wr(6'h0C, 16'h0000);

        // R2 R3: register table
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][38], VEC[i][37:32], VEC[i][31:16], 2'b01, 1'b0, 8'h00);
            if (!VEC[i][38]) chk("R3 R2 table read", r_data, VEC[i][15:0]);
        end

        // R6 R11: transmit strobe, with and without transmit interrupt enable
        wr(6'h00, 16'h01C5);
        chk("R6 strobe", {15'd0, p_stb}, 16'd1);
        chk("R6 byte", {8'd0, p_txb}, 16'h00C5);
        chk("R11 no tx irq", {15'd0, p_itx}, 16'd0);
        wr(6'h04, 16'h0002);
        wr(6'h00, 16'h003A);
        chk("R11 tx irq", {15'd0, p_itx}, 16'd1);
        chk("R6 byte2", {8'd0, p_txb}, 16'h003A);

        // R2: divisor write does not transmit
        wr(6'h0C, 16'h0080);
        wr(6'h00, 16'h0042);
        chk("R2 no strobe", {15'd0, p_stb}, 16'd0);
        rd(6'h00); chk("R2 divl", r_data, 16'h0042);
        wr(6'h0C, 16'h0000);

        // R4: size errors, also at an unmapped offset
        acc(1'b1, 6'h1C, 16'h1111, 2'b10, 1'b0, 8'h00);
        chk("R4 err", {14'd0, r_err, r_esz}, 16'h0003);
        acc(1'b0, 6'h20, 16'h0000, 2'b00, 1'b0, 8'h00);
        chk("R4 err priority", {14'd0, r_err, r_esz}, 16'h0003);
        rd(6'h1C); chk("R4 scratch kept", r_data, 16'hBEEF);

        // R5: unmapped offsets
        wr(6'h18, 16'h5555); chk("R5 slot6", {14'd0, r_err, r_esz}, 16'h0002);
        wr(6'h20, 16'h5555); chk("R5 slot8", {14'd0, r_err, r_esz}, 16'h0002);
        wr(6'h0E, 16'h5555); chk("R5 misaligned", {14'd0, r_err, r_esz}, 16'h0002);
        wr(6'h28, 16'h5555); chk("R5 beyond", {14'd0, r_err, r_esz}, 16'h0002);
        rd(6'h18); chk("R5 read zero", r_data, 16'h0000);
        rd(6'h0C); chk("R5 lctl kept", r_data, 16'h0000);

        // R7 R9: receive path and live status
        tx_line_idle = 1'b1;
        inject(8'h5A);
        rd(6'h14); chk("R9 live dr", r_data, 16'h0061);
        rd(6'h00); chk("R7 rbr", r_data, 16'h005A);
        rd(6'h14); chk("R7 dr cleared", r_data, 16'h0060);
        rd(6'h00); chk("R7 rbr repeat", r_data, 16'h005A);

        // R8: overrun, then same-cycle read and arrival
        inject(8'h11);
        inject(8'h22);
        rd(6'h14); chk("R8 overrun", r_data, 16'h0063);
        rd(6'h14); chk("R8 sticky cleared", r_data, 16'h0061);
        rd(6'h00); chk("R8 newest byte", r_data, 16'h0022);
        inject(8'h33);
        acc(1'b0, 6'h00, 16'h0000, 2'b01, 1'b1, 8'h44);
        chk("R8 same-cycle old byte", r_data, 16'h0033);
        rd(6'h14); chk("R8 no overrun", r_data, 16'h0061);
        rd(6'h00); chk("R8 same-cycle new byte", r_data, 16'h0044);

        // R11: receive interrupt level
        wr(6'h04, 16'h0001);
        inject(8'h66);
        chk("R11 rx irq", {15'd0, p_irx}, 16'd1);
        rd(6'h00);
        chk("R11 rx irq drop", {15'd0, p_irx}, 16'd0);

        // R10: loopback
        wr(6'h10, 16'h0010);
        inject(8'h77);
        rd(6'h14); chk("R10 ext ignored dr", r_data, 16'h0060);
        rd(6'h00); chk("R10 ext ignored rbr", r_data, 16'h0066);
        wr(6'h00, 16'h009C);
        chk("R10 still transmits", {15'd0, p_stb}, 16'd1);
        rd(6'h14); chk("R10 loop dr", r_data, 16'h0061);
        rd(6'h00); chk("R10 loop byte", r_data, 16'h009C);
        rd(6'h14); chk("R10 consumed", r_data, 16'h0060);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule